// File: doc/BRIEF.md
# Parallel Printer Port Interrupt Generator

This block produces the interrupt line of a PC-style parallel printer port and the status byte that goes with it. The printer pulses its acknowledge line low when a byte transfer has completed. The rising transition at the end of that pulse is the interrupt event. Three printer inputs (acknowledge, error, busy) are asynchronous. Each passes through a two-stage synchronizer before any logic uses it.

A static strap chooses how the interrupt line behaves. With the strap low, the interrupt line simply carries the synchronized acknowledge level. With the strap high, a rising edge of the synchronized acknowledge sets a pending flag, and the interrupt line shows that flag. The flag stays set until the CPU reads the status register. The status register holds a PRINT bit that is the inverse of the pending flag, together with the synchronized levels of the error, acknowledge and busy inputs.

A read of the status register is recognised only when chip select, the read strobe and the status address are all present together. The read returns the value held before the clear. The flag is cleared at the clock edge that ends the read cycle. A new acknowledge edge in that same cycle takes priority, so the event is not lost.

Top module: `prn_irq_ctrl`

## Requirements
- R1: After reset the pending flag is clear. PRINT reads 1, stat_rd is 0 and rd_data is 0 while no read is active. With prn_ack high, the interrupt in pass-through mode is 1.
- R2: prn_ack, prn_err_n and prn_busy each pass through two clock stages. A level driven before rising edge k appears in the status fields and in the pass-through interrupt after edge k+1, and not before.
- R3: With mode_sel = 0, irq equals the synchronized prn_ack level.
- R4: A low-to-high change of the synchronized prn_ack sets the pending flag at the next rising edge. This is the third rising edge after the change is driven. A high-to-low change never sets the flag.
- R5: With mode_sel = 1, irq equals the pending flag, which is the inverse of the PRINT status bit.
- R6: stat_rd is 1 exactly when cs = 1, rd = 1 and addr = 1. In that cycle rd_data carries the status byte. Otherwise rd_data is 0.
- R7: Status byte layout: bit 0 is PRINT (0 means an interrupt is pending), bit 1 is the synchronized prn_err_n, bit 2 is the synchronized prn_ack, bit 3 is the synchronized prn_busy, and bits 7 to 4 are 0.
- R8: A status read returns the PRINT value held before the clear. The pending flag is 0 from the rising edge that ends the read cycle.
- R9: If a rising acknowledge edge and a status read fall in the same cycle, the pending flag is set after that edge.
- R10: A read with cs = 0, or with addr other than 1, leaves the pending flag and irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Static strap: 0 selects pass-through, 1 selects latched read-to-clear |
| prn_ack | input | 1 | Printer acknowledge, active low, asynchronous |
| prn_err_n | input | 1 | Printer error, active low, asynchronous |
| prn_busy | input | 1 | Printer busy, high when the printer cannot accept data, asynchronous |
| cs | input | 1 | Chip select for the printer port |
| rd | input | 1 | CPU read strobe |
| addr | input | 3 | CPU register address |
| stat_rd | output | 1 | Qualified status-register read strobe |
| rd_data | output | 8 | Read data, status byte during a qualified status read |
| irq | output | 1 | Printer port interrupt |

## Verification
The hardest case to reach is a status read that falls in exactly the cycle where the synchronized acknowledge rises. Getting there means counting through both synchronizer stages from the moment the pin is driven. The directed part of the bench raises prn_ack and then asserts the qualified read two falling edges later. It then checks that the read shows PRINT still idle and that irq stays set after the edge. A long pseudo-random sweep in each mode follows. It mixes acknowledge toggles with reads that are often at the status address, so this coincidence and reads with a wrong qualifier come up many times. Each cycle is compared against a cycle model kept in the bench.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;

  typedef enum logic {
    IRQ_MODE_PASS  = 1'b0,
    IRQ_MODE_LATCH = 1'b1
  } irq_mode_e;

  // status fields, most significant first: busy=bit3 ack=bit2 err=bit1 print=bit0
  typedef struct packed {
    logic busy;
    logic ack;
    logic err;
    logic print;
  } prn_stat_t;

  localparam int STAT_W = $bits(prn_stat_t);

  // next value of the pending flag: a new event wins over a clear
  function automatic logic pend_next(logic pend, logic set_evt, logic clr_evt);
    logic nxt;
    if (set_evt)      nxt = 1'b1;
    else if (clr_evt) nxt = 1'b0;
    else              nxt = pend;
    return nxt;
  endfunction

  // interrupt line picked by the strap
  function automatic logic irq_pick(irq_mode_e mode, logic ack_lvl, logic pend);
    return (mode == IRQ_MODE_LATCH) ? pend : ack_lvl;
  endfunction

  // assemble the status fields from levels and the pending flag
  function automatic prn_stat_t stat_build(logic busy, logic ack, logic err, logic pend);
    prn_stat_t s;
    s.busy  = busy;
    s.ack   = ack;
    s.err   = err;
    s.print = ~pend;
    return s;
  endfunction

endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/prn_edge_det.sv
module prn_edge_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= RST_VAL;
    else        lvl_prev <= lvl;
  end

  assign rise = lvl & ~lvl_prev;

endmodule

// File: rtl/prn_irq_latch.sv
module prn_irq_latch
  import prn_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next(pend, set_evt, clr_evt);
  end

endmodule

// File: rtl/prn_stat_port.sv
module prn_stat_port
  import prn_irq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 1
) (
  input  logic              cs,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  prn_stat_t         stat,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - STAT_W;

  assign hit = cs & rd & (addr == ADDR_W'(STAT_ADDR));

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = hit ? {{PAD_W{1'b0}}, stat} : '0;
    end else begin : g_nopad
      assign rd_data = hit ? DATA_W'(stat) : '0;
    end
  endgenerate

endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int STAT_ADDR   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              prn_ack,
  input  logic              prn_err_n,
  input  logic              prn_busy,
  input  logic              cs,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int N_LINES = 3;
  // idle levels: busy low, error high, ack high
  localparam logic [N_LINES-1:0] LINE_IDLE = 3'b011;

  logic [N_LINES-1:0] line_sync;
  logic               ack_lvl;
  logic               err_lvl;
  logic               busy_lvl;
  logic               rise_evt;
  logic               irq_pend;
  prn_stat_t          stat_now;
  irq_mode_e          mode;

  prn_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({prn_busy, prn_err_n, prn_ack}),
    .q_sync (line_sync)
  );

  assign ack_lvl  = line_sync[0];
  assign err_lvl  = line_sync[1];
  assign busy_lvl = line_sync[2];

  prn_edge_det #(.RST_VAL(LINE_IDLE[0])) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ack_lvl),
    .rise (rise_evt)
  );

  prn_irq_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(rise_evt),
    .clr_evt(stat_rd),
    .pend   (irq_pend)
  );

  assign stat_now = stat_build(busy_lvl, ack_lvl, err_lvl, irq_pend);

  prn_stat_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_ADDR(STAT_ADDR)
  ) u_port (
    .cs     (cs),
    .rd     (rd),
    .addr   (addr),
    .stat   (stat_now),
    .hit    (stat_rd),
    .rd_data(rd_data)
  );

  assign mode = irq_mode_e'(mode_sel);
  assign irq  = irq_pick(mode, ack_lvl, irq_pend);

endmodule

// File: rtl/prn_irq_chk.sv
module prn_irq_chk #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              cs,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic              stat_rd,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              ack_lvl,
  input logic              rise_evt,
  input logic              irq_pend
);

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> irq_pend);

  // R4
  edge_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (ack_lvl && !$past(ack_lvl)));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rise_evt) |=> !irq_pend);

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !stat_rd) |=> irq_pend);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pend && !rise_evt) |=> !irq_pend);

  // R3
  pass_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |-> (irq == ack_lvl));

  // R5
  latch_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && stat_rd) |-> (irq == !rd_data[0]));

  // R6
  qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (cs && rd && addr == ADDR_W'(STAT_ADDR)));

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |-> (rd_data == '0));

endmodule

bind prn_irq_ctrl prn_irq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .STAT_ADDR(STAT_ADDR)
) u_prn_irq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_sel(mode_sel),
  .cs      (cs),
  .rd      (rd),
  .addr    (addr),
  .stat_rd (stat_rd),
  .rd_data (rd_data),
  .irq     (irq),
  .ack_lvl (ack_lvl),
  .rise_evt(rise_evt),
  .irq_pend(irq_pend)
);

// File: tb/test_prn_irq_ctrl.sv
`timescale 1ns/1ps
module test_prn_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b1;
  logic       prn_ack = 1'b1;
  logic       prn_err_n = 1'b1;
  logic       prn_busy = 1'b0;
  logic       cs = 1'b0;
  logic       rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       stat_rd;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prn_irq_ctrl i_prn_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .prn_ack(prn_ack), .prn_err_n(prn_err_n), .prn_busy(prn_busy),
    .cs(cs), .rd(rd), .addr(addr),
    .stat_rd(stat_rd), .rd_data(rd_data), .irq(irq)
  );

  // cycle model built from the requirements: two sync stages, one edge stage
  logic m_a1, m_a2, m_a3, m_e1, m_e2, m_b1, m_b2, m_p;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a1 = 1; m_a2 = 1; m_a3 = 1; m_e1 = 1; m_e2 = 1;
      m_b1 = 0; m_b2 = 0; m_p = 0;
    end else begin
      if (m_a2 && !m_a3)                    m_p = 1;
      else if (cs && rd && addr == 3'd1)    m_p = 0;
      m_a3 = m_a2; m_a2 = m_a1; m_a1 = prn_ack;
      m_e2 = m_e1; m_e1 = prn_err_n;
      m_b2 = m_b1; m_b1 = prn_busy;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd_on();  cs = 1; rd = 1; addr = 3'd1; endtask
  task automatic rd_off(); cs = 0; rd = 0; addr = 3'd0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic        hit;
    repeat (3) tick();
    rst_n = 1;
    tick(); #1;
    // R1 reset state
    chk("R1 irq latched", irq, 0);
    chk("R1 stat_rd", stat_rd, 0);
    chk("R1 rd_data idle", rd_data, 0);
    rd_on(); #1;
    chk("R1 R7 status after reset", rd_data, 8'h07);
    chk("R6 stat_rd on hit", stat_rd, 1);
    rd_off();
    mode_sel = 0; #1;
    chk("R1 irq pass", irq, 1);

    // R2 R3 ack falling through two stages
    tick(); prn_ack = 0; #1;
    chk("R3 irq before edge", irq, 1);
    tick(); #1;
    chk("R2 irq after one edge", irq, 1);
    tick(); #1;
    chk("R2 R3 irq after two edges", irq, 0);

    // R4 R5 rising edge sets pending
    tick(); prn_ack = 1; #1;
    tick(); #1;
    chk("R2 irq one edge after rise", irq, 0);
    tick(); #1;
    chk("R3 irq follows ack", irq, 1);
    mode_sel = 1; #1;
    chk("R4 not yet pending", irq, 0);
    tick(); #1;
    chk("R4 R5 pending set", irq, 1);

    // R10 disqualified reads
    cs = 0; rd = 1; addr = 3'd1; #1;
    chk("R10 no stat_rd cs low", stat_rd, 0);
    tick(); cs = 1; rd = 1; addr = 3'd2; #1;
    chk("R10 rd_data wrong addr", rd_data, 0);
    tick(); rd_off(); #1;
    chk("R10 irq kept", irq, 1);

    // R8 read returns pre-clear value then clears
    tick(); rd_on(); #1;
    chk("R8 R7 PRINT low during read", rd_data, 8'h06);
    chk("R5 irq pending during read", irq, 1);
    tick(); rd_off(); #1;
    chk("R8 cleared after read", irq, 0);
    rd_on(); #1;
    chk("R8 PRINT idle after clear", rd_data[0], 1);
    rd_off();

    // R4 falling edge does not set
    tick(); prn_ack = 0;
    repeat (4) tick(); #1;
    chk("R4 falling no event", irq, 0);

    // R9 edge coinciding with read
    prn_ack = 1;
    tick(); tick(); rd_on(); #1;
    chk("R9 read shows idle PRINT", rd_data[0], 1);
    tick(); rd_off(); #1;
    chk("R9 set wins over clear", irq, 1);
    rd_on(); tick(); rd_off(); #1;
    chk("R8 clear after coincidence", irq, 0);

    // R2 R7 error and busy fields
    tick(); prn_err_n = 0; prn_busy = 1;
    tick(); rd_on(); #1;
    chk("R2 fields one edge late", rd_data, 8'h07);
    tick(); #1;
    chk("R2 R7 fields updated", rd_data, 8'h0D);
    rd_off(); prn_err_n = 1; prn_busy = 0;
    repeat (3) tick();

    // sweep both modes against the cycle model: R3 R5 R6 R7
    lf = 16'hACE1;
    for (int md = 0; md < 2; md++) begin
      rst_n = 0; mode_sel = md[0];
      prn_ack = 1; prn_err_n = 1; prn_busy = 0; rd_off();
      repeat (2) tick();
      rst_n = 1;
      for (int c = 0; c < 3000; c++) begin
        tick();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[1:0] == 2'b00) prn_ack = ~prn_ack;
        prn_err_n = lf[2] | lf[3];
        prn_busy  = lf[4];
        cs = lf[5] | lf[11];
        rd = lf[6] | lf[12];
        addr = lf[9] ? 3'd1 : lf[15:13];
        #1;
        hit = cs && rd && addr == 3'd1;
        chk(md ? "R5 sweep irq" : "R3 sweep irq", irq, md ? m_p : m_a2);
        chk("R6 sweep stat_rd", stat_rd, hit);
        chk("R7 sweep rd_data", rd_data,
            hit ? {4'b0, m_b2, m_a2, m_e2, ~m_p} : 8'h00);
      end
    end
    finish_run();
  end

endmodule